// File: doc/BRIEF.md
# Dual-Compare Output Modulator

This block merges the waveform outputs of two independent compare channels onto a single shared output pin. One channel supplies a fast carrier and the other supplies a slower modulating PWM. Each channel has a 2-bit output-mode field. A field of zero means the channel leaves the pin alone. Any other value means the channel claims the pin. The pin's ordinary port data bit drives the pin whenever no channel claims it.

When exactly one channel is enabled, that channel's waveform reaches the pin. When both are enabled at once, modulation turns on by itself. In that case the port data bit is no longer a pin level: it picks the combining function. A port bit of 0 gives the AND of the two waveforms, and a port bit of 1 gives the OR.

A small state machine records which source currently owns the pin. Its states are SRC_PORT, SRC_CARRIER, SRC_MOD and SRC_BLEND. Each clock, the enable pattern of the two channels selects the next state:

- T_TO_PORT: neither channel enabled.
- T_TO_CARRIER: only the carrier channel enabled.
- T_TO_MOD: only the modulating channel enabled.
- T_TO_BLEND: both channels enabled.

Any state can reach any other state in one clock. The pin level is registered on the same edge, so a change of source never glitches the pin.

The effective PWM resolution shrinks by the number of system clocks in one carrier period. Two modulating high times that differ by a single cycle can give the same pin result.

Top module: `oc_mod_top`

## Requirements
- R1: While rst_n is low, pin_out is 0 and the source state is SRC_PORT.
- R2: When carrier_mode and mod_mode are both 2'b00, pin_out equals the port_bit sampled at the previous rising clock edge, and both waveform inputs have no effect.
- R3: When carrier_mode is nonzero and mod_mode is 2'b00, pin_out equals the carrier_wave sampled at the previous rising edge; mod_wave and port_bit have no effect.
- R4: When mod_mode is nonzero and carrier_mode is 2'b00, pin_out equals the mod_wave sampled at the previous rising edge; carrier_wave and port_bit have no effect.
- R5: When both mode fields are nonzero and port_bit is 0, pin_out equals carrier_wave AND mod_wave, all sampled at the previous rising edge.
- R6: When both mode fields are nonzero and port_bit is 1, pin_out equals carrier_wave OR mod_wave, all sampled at the previous rising edge.
- R7: Each of the nonzero mode values 2'b01, 2'b10 and 2'b11 enables its channel in the same way; the value itself does not change the pin result.
- R8: When the enable pattern changes, the first pin value after the change already comes from the new source, with no cycle of stale data from the old source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_wave | input | 1 | Compare waveform of the carrier timer |
| carrier_mode | input | MODE_W | Output-mode field of the carrier channel; nonzero enables it |
| mod_wave | input | 1 | Compare waveform of the modulating timer |
| mod_mode | input | MODE_W | Output-mode field of the modulating channel; nonzero enables it |
| port_bit | input | 1 | Port data bit; pin level when idle, combine selector when both channels are enabled |
| pin_out | output | 1 | Registered level of the shared pin |

## Verification
Two functions can fall in the same cycle: a change of pin source, and an edge on a waveform or on port_bit. A harder case is port_bit toggling in the very cycle the block enters or leaves blend mode, since port_bit is then data on one side and selector on the other. The bench provokes these by changing mode fields, waveforms and port_bit together in directed steps and in a long pseudo-random stretch. A behavioural model judges every clock from the inputs held at the previous edge, and it tags each source switch against R8.

// File: rtl/oc_mod_pkg.sv
package oc_mod_pkg;

    // Which source currently owns the shared pin
    typedef enum logic [1:0] {
        SRC_PORT    = 2'd0,
        SRC_CARRIER = 2'd1,
        SRC_MOD     = 2'd2,
        SRC_BLEND   = 2'd3
    } src_sel_e;

    // Channel index positions in the enable vector
    localparam int unsigned CH_CARRIER = 0;
    localparam int unsigned CH_MOD     = 1;
    localparam int unsigned NUM_CH     = 2;

endpackage

// File: rtl/oc_mod_chan_detect.sv
module oc_mod_chan_detect #(
    parameter int unsigned MODE_W = 2
) (
    input  logic [MODE_W-1:0] mode,
    output logic              active
);

    // A channel claims the pin for every nonzero mode value
    always_comb begin
        active = |mode;
    end

endmodule

// File: rtl/oc_mod_next_src.sv
module oc_mod_next_src
    import oc_mod_pkg::*;
(
    input  logic [NUM_CH-1:0] active,
    output src_sel_e          nxt
);

    always_comb begin
        nxt = SRC_PORT;
        unique case (active)
            2'b00: nxt = SRC_PORT;     // T_TO_PORT
            2'b01: nxt = SRC_CARRIER;  // T_TO_CARRIER
            2'b10: nxt = SRC_MOD;      // T_TO_MOD
            2'b11: nxt = SRC_BLEND;    // T_TO_BLEND
            default: nxt = SRC_PORT;
        endcase
    end

endmodule

// File: rtl/oc_mod_blend.sv
module oc_mod_blend
    import oc_mod_pkg::*;
(
    input  src_sel_e sel,
    input  logic     carrier_wave,
    input  logic     mod_wave,
    input  logic     port_bit,
    output logic     level
);

    always_comb begin
        level = 1'b0;
        unique case (sel)
            SRC_PORT:    level = port_bit;
            SRC_CARRIER: level = carrier_wave;
            SRC_MOD:     level = mod_wave;
            SRC_BLEND:   level = port_bit ? (carrier_wave | mod_wave)
                                          : (carrier_wave & mod_wave);
            default:     level = 1'b0;
        endcase
    end

endmodule

// File: rtl/oc_mod_top.sv
module oc_mod_top
    import oc_mod_pkg::*;
#(
    parameter int unsigned MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              carrier_wave,
    input  logic [MODE_W-1:0] carrier_mode,
    input  logic              mod_wave,
    input  logic [MODE_W-1:0] mod_mode,
    input  logic              port_bit,
    output logic              pin_out
);

    logic [NUM_CH-1:0][MODE_W-1:0] mode_vec;
    logic [NUM_CH-1:0]             ch_active;
    src_sel_e                      state_q;
    src_sel_e                      state_d;
    logic                          level_d;
    logic                          pin_q;

    always_comb begin
        mode_vec[CH_CARRIER] = carrier_mode;
        mode_vec[CH_MOD]     = mod_mode;
    end

    // One enable detector per channel
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        oc_mod_chan_detect #(
            .MODE_W (MODE_W)
        ) u_detect (
            .mode   (mode_vec[ch]),
            .active (ch_active[ch])
        );
    end

    oc_mod_next_src u_next (
        .active (ch_active),
        .nxt    (state_d)
    );

    oc_mod_blend u_blend (
        .sel          (state_d),
        .carrier_wave (carrier_wave),
        .mod_wave     (mod_wave),
        .port_bit     (port_bit),
        .level        (level_d)
    );

    // State register: which source owns the pin
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SRC_PORT;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: pin level from the source chosen on this edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else begin
            pin_q <= level_d;
        end
    end

    assign pin_out = pin_q;

    // ---------------- assertions ----------------
    always_comb begin
        if (!rst_n) begin
            AST_RESET_PIN_LOW: assert (pin_out == 1'b0 && state_q == SRC_PORT); // R1
        end
    end

    AST_IDLE_PORT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier_mode == '0 && mod_mode == '0) |=> (pin_out == $past(port_bit))); // R2

    AST_CARRIER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier_mode != '0 && mod_mode == '0) |=> (pin_out == $past(carrier_wave))); // R3

    AST_MOD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier_mode == '0 && mod_mode != '0) |=> (pin_out == $past(mod_wave))); // R4

    AST_BLEND_AND: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier_mode != '0 && mod_mode != '0 && !port_bit)
        |=> (pin_out == ($past(carrier_wave) && $past(mod_wave)))); // R5

    AST_BLEND_OR: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier_mode != '0 && mod_mode != '0 && port_bit)
        |=> (pin_out == ($past(carrier_wave) || $past(mod_wave)))); // R6

    AST_BLEND_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier_mode != '0 && mod_mode != '0) |=> (state_q == SRC_BLEND)); // R7

    AST_SWITCH_NO_STALE: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier_mode == '0 && mod_mode == '0 && !$stable(mod_mode))
        |=> (state_q == SRC_PORT && pin_out == $past(port_bit))); // R8

endmodule

// File: tb/tb_oc_mod_top.sv
module tb_oc_mod_top;

    logic       clk;
    logic       rst_n;
    logic       carrier_wave;
    logic [1:0] carrier_mode;
    logic       mod_wave;
    logic [1:0] mod_mode;
    logic       port_bit;
    logic       pin_out;

    int checks_total = 0;
    int checks_fail  = 0;
    bit done         = 0;

    bit    exp_q[$];
    string tag_q[$];
    int    prev_sel = 0;

    oc_mod_top #(.MODE_W(2)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .carrier_wave (carrier_wave),
        .carrier_mode (carrier_mode),
        .mod_wave     (mod_wave),
        .mod_mode     (mod_mode),
        .port_bit     (port_bit),
        .pin_out      (pin_out)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Behavioural reference: one expected pin value per rising edge
    always @(posedge clk) begin
        int    sel;
        bit    e;
        string t;
        if (!rst_n) begin
            e = 0;
            t = "R1";
            prev_sel = 0;
        end else begin
            sel = (carrier_mode != 0 ? 1 : 0) + (mod_mode != 0 ? 2 : 0);
            case (sel)
                0: begin e = port_bit;     t = "R2"; end
                1: begin e = carrier_wave; t = "R3"; end
                2: begin e = mod_wave;     t = "R4"; end
                default: begin
                    if (port_bit) begin
                        e = (carrier_wave + mod_wave) > 0;
                        t = "R6";
                    end else begin
                        e = (carrier_wave + mod_wave) == 2;
                        t = "R5";
                    end
                end
            endcase
            if ((carrier_mode > 1) || (mod_mode > 1)) t = {t, " R7"};
            if (sel != prev_sel) t = {t, " R8"};
            prev_sel = sel;
        end
        exp_q.push_back(e);
        tag_q.push_back(t);
    end

    task automatic check_one();
        bit    e;
        string t;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks_total++;
            if (pin_out !== e) begin
                checks_fail++;
                $display("FAIL %s: pin_out=%0b expected=%0b at %0t", t, pin_out, e, $time);
            end
        end
    endtask

    task automatic step(input bit c, input bit m, input logic [1:0] cm,
                        input logic [1:0] mm, input bit p);
        @(negedge clk);
        check_one();
        carrier_wave = c;
        mod_wave     = m;
        carrier_mode = cm;
        mod_mode     = mm;
        port_bit     = p;
    endtask

    initial begin
        logic [15:0] lfsr;
        rst_n = 1'b0;
        carrier_wave = 0; mod_wave = 0; carrier_mode = 0; mod_mode = 0; port_bit = 0;
        // R1: reset holds pin low even with active-looking inputs
        step(1, 1, 2'd0, 2'd0, 1);
        step(1, 1, 2'd1, 2'd0, 1);
        step(1, 1, 2'd0, 2'd0, 1);
        @(negedge clk);
        check_one();
        rst_n = 1'b1;

        // R2: idle, port passes, waveforms ignored
        step(1, 1, 0, 0, 0);
        step(0, 0, 0, 0, 1);
        step(1, 0, 0, 0, 1);
        // R3: carrier only, all enabling values, port/mod ignored
        for (int v = 1; v < 4; v++) begin
            step(1, 0, v[1:0], 0, 0);
            step(0, 1, v[1:0], 0, 1);
        end
        // R4: mod only
        for (int v = 1; v < 4; v++) begin
            step(0, 1, 0, v[1:0], 0);
            step(1, 0, 0, v[1:0], 1);
        end
        // R5 / R6: blend, all four waveform pairs under both selectors
        for (int p = 0; p < 2; p++) begin
            for (int w = 0; w < 4; w++) begin
                step(w[0], w[1], 2'd3, 2'd2, p[0]);
            end
        end
        // R8: switches with simultaneous data and selector edges
        step(1, 0, 1, 1, 1);
        step(1, 0, 0, 0, 0);
        step(0, 1, 1, 1, 0);
        step(1, 1, 0, 2, 1);
        step(0, 0, 3, 3, 1);
        step(1, 0, 2, 0, 0);

        // Pseudo-random stretch
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr[1], lfsr[3:2], lfsr[5:4], lfsr[6]);
        end

        @(negedge clk);
        check_one();
        done = 1;
        $display("%0d/%0d checks passed", checks_total - checks_fail, checks_total);
        $finish;
    end

    initial begin
        #(2_000_000);
        if (!done) begin
            checks_total++;
            checks_fail++;
            $display("FAIL watchdog: pin_out=%0b expected=run complete", pin_out);
            $display("%0d/%0d checks passed", checks_total - checks_fail, checks_total);
            $finish;
        end
    end

endmodule